// File: doc/BRIEF.md
# Interrupt Pin Redirection Controller

This block turns a bank of external interrupt pins into interrupt messages. Every pin owns a programmable table entry. The entry holds the vector number, the delivery mode, the polarity, the trigger kind, a mask bit and a 16-bit destination. When an unmasked pin becomes active, the block issues one message carrying that entry's vector, mode and destination on a valid/ready output.

Software programs the block through an indexed register window. It places an offset on the select input. It then reads the data one cycle later, or writes a 32-bit word. A separate write-only port takes end-of-interrupt vectors. These release level-triggered entries that are waiting on remote-pending.

Pins pass through a two-flop synchronizer before edge detection. When several pins are waiting, the lowest-numbered pin is sent first.

Top module: `irq_redirect_top`

## Requirements
- R1: After reset, msg_valid is 0. Every entry's low word reads 0x00010000, which is masked with all other fields zero. Every entry's high word reads 0.
- R2: Select offset 0x01 reads the version word. Bits 7:0 hold VERSION (0x21), bits 23:16 hold NPINS-1 (0x17 for 24 pins), and all other bits are 0.
- R3: Offset 0x10+2*i is entry i's low word: vector[7:0], delivery mode[10:8], polarity[13], remote-pending[14] (read-only), trigger[15], mask[16]. Offset 0x11+2*i is the high word, with the destination in bits 31:16 (processor ID 31:24, extended ID 23:16). Read data appears one cycle after the select. Mode codes are fixed=0, lowest priority=1, PMI=2 and INIT=5. They are carried through unchanged.
- R4: An edge entry (trigger 0) that is unmasked sends exactly one message for each inactive-to-active transition of its pin. The message carries the entry's vector, mode and destination, and msg_pin gives the pin index.
- R5: An edge that occurs while the entry is masked is dropped. Clearing the mask afterwards produces no message.
- R6: A level entry (trigger 1) that is unmasked and active sends one message and sets remote-pending. It sends nothing more until an end-of-interrupt write carries the entry's vector. An end-of-interrupt write with any other vector has no effect.
- R7: One end-of-interrupt write releases every level entry whose vector equals the written vector.
- R8: Polarity 0 treats a high pin as active. Polarity 1 treats a low pin as active.
- R9: A high-word write only stages the destination. Messages use the new destination only after the entry's low word has been written.
- R10: When several pins are waiting, the lowest-numbered pin is sent first. While msg_valid is high and msg_ready is low, the message fields and msg_valid stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NPINS | Asynchronous interrupt pins |
| reg_sel | input | 8 | Register window select offset |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the select presented in the previous cycle |
| eoi_wr | input | 1 | End-of-interrupt write strobe |
| eoi_vec | input | 8 | End-of-interrupt vector |
| msg_valid | output | 1 | Message available |
| msg_ready | input | 1 | Message accepted by the consumer |
| msg_vector | output | 8 | Message vector |
| msg_mode | output | 3 | Message delivery mode |
| msg_dest | output | 16 | Message destination |
| msg_pin | output | clog2(NPINS) | Index of the originating pin |

## Verification
The bench pulses a pin while its entry is masked and then unmasks it. A design that latched the edge would emit a late message at that point.

Level inputs are held active across a non-matching end-of-interrupt write and then a matching one. A design that ignored remote-pending would flood the output. A design that compared vectors wrongly would release on the wrong write or never re-send.

The bench also targets one shared vector releasing two pins at once, and a staged destination that must not leak before the low-word write. It checks lowest-pin ordering and payload hold under back-pressure. Randomly programmed edge entries check that vector, mode and destination pass through.

// File: rtl/irq_redir_pkg.sv
package irq_redir_pkg;
  // low-word bit positions
  localparam int LO_MODE_LSB = 8;
  localparam int LO_POL_BIT  = 13;
  localparam int LO_RP_BIT   = 14;
  localparam int LO_TRIG_BIT = 15;
  localparam int LO_MASK_BIT = 16;
  localparam logic [7:0] SEL_VERSION = 8'h01;
  localparam logic [7:0] SEL_TABLE   = 8'h10;

  typedef struct packed {
    logic [7:0] vec;
    logic [2:0] mode;
    logic       pol;
    logic       trig;
    logic       mask;
  } ent_lo_t;

  function automatic ent_lo_t lo_from_word(input logic [31:0] w);
    ent_lo_t e;
    e.vec  = w[7:0];
    e.mode = w[LO_MODE_LSB +: 3];
    e.pol  = w[LO_POL_BIT];
    e.trig = w[LO_TRIG_BIT];
    e.mask = w[LO_MASK_BIT];
    return e;
  endfunction

  function automatic logic [31:0] lo_to_word(input ent_lo_t e, input logic rp);
    logic [31:0] w;
    w = '0;
    w[7:0] = e.vec;
    w[LO_MODE_LSB +: 3] = e.mode;
    w[LO_POL_BIT]  = e.pol;
    w[LO_RP_BIT]   = rp;
    w[LO_TRIG_BIT] = e.trig;
    w[LO_MASK_BIT] = e.mask;
    return w;
  endfunction
endpackage

// File: rtl/irq_pin_front.sv
module irq_pin_front #(
  parameter int NPINS = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] pin_in,
  input  logic [NPINS-1:0] pol,
  output logic [NPINS-1:0] act,
  output logic [NPINS-1:0] rise
);
  logic [NPINS-1:0] s1_q, s2_q, prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q   <= '0;
      s2_q   <= '0;
      prev_q <= '0;
    end else begin
      s1_q   <= pin_in;
      s2_q   <= s1_q;
      prev_q <= act;
    end
  end

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    assign act[g]  = s2_q[g] ^ pol[g];
    assign rise[g] = act[g] & ~prev_q[g];
  end
endmodule

// File: rtl/irq_lowest_pick.sv
module irq_lowest_pick #(
  parameter int NPINS = 24,
  localparam int PW = (NPINS > 1) ? $clog2(NPINS) : 1
) (
  input  logic [NPINS-1:0] req,
  input  logic             en,
  output logic [NPINS-1:0] grant,
  output logic             any,
  output logic [PW-1:0]    gidx
);
  always_comb begin
    grant = '0;
    any   = 1'b0;
    gidx  = '0;
    if (en) begin
      for (int i = NPINS - 1; i >= 0; i--) begin
        if (req[i]) begin
          grant    = '0;
          grant[i] = 1'b1;
          any      = 1'b1;
          gidx     = PW'(i);
        end
      end
    end
  end
endmodule

// File: rtl/irq_redirect_top.sv
module irq_redirect_top
  import irq_redir_pkg::*;
#(
  parameter int         NPINS   = 24,
  parameter logic [7:0] VERSION = 8'h21,
  localparam int PW = (NPINS > 1) ? $clog2(NPINS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] irq_in,
  input  logic [7:0]       reg_sel,
  input  logic             reg_wr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic             eoi_wr,
  input  logic [7:0]       eoi_vec,
  output logic             msg_valid,
  input  logic             msg_ready,
  output logic [7:0]       msg_vector,
  output logic [2:0]       msg_mode,
  output logic [15:0]      msg_dest,
  output logic [PW-1:0]    msg_pin
);
  localparam logic [31:0] VER_WORD = {8'h00, 8'(NPINS - 1), 8'h00, VERSION};

  ent_lo_t          lo_q  [NPINS];
  logic [15:0]      hi_q  [NPINS];
  logic [15:0]      dst_q [NPINS];
  logic [NPINS-1:0] rirr_q, epend_q;
  logic [NPINS-1:0] pol_v, trig_v, mask_v, act, rise, req, grant, eoi_hit;
  logic [NPINS-1:0] lo_we, hi_we;
  logic             any, load;
  logic [PW-1:0]    gidx;

  // window decode
  logic [7:0]    sel_off;
  logic [6:0]    sel_idx;
  logic [PW-1:0] tidx;
  logic          is_tbl;
  assign sel_off = reg_sel - SEL_TABLE;
  assign sel_idx = sel_off[7:1];
  assign tidx    = sel_idx[PW-1:0];
  assign is_tbl  = (reg_sel >= SEL_TABLE) && (32'(sel_idx) < NPINS);

  irq_pin_front #(.NPINS(NPINS)) u_front (
    .clk(clk), .rst(rst), .pin_in(irq_in), .pol(pol_v), .act(act), .rise(rise)
  );

  assign load = !msg_valid || msg_ready;

  irq_lowest_pick #(.NPINS(NPINS)) u_pick (
    .req(req), .en(load), .grant(grant), .any(any), .gidx(gidx)
  );

  for (genvar g = 0; g < NPINS; g++) begin : g_ent
    assign pol_v[g]   = lo_q[g].pol;
    assign trig_v[g]  = lo_q[g].trig;
    assign mask_v[g]  = lo_q[g].mask;
    assign lo_we[g]   = reg_wr && is_tbl && !sel_off[0] && (tidx == PW'(g));
    assign hi_we[g]   = reg_wr && is_tbl &&  sel_off[0] && (tidx == PW'(g));
    assign eoi_hit[g] = eoi_wr && lo_q[g].trig && (lo_q[g].vec == eoi_vec);
    assign req[g]     = !mask_v[g] && (trig_v[g] ? (act[g] && !rirr_q[g]) : epend_q[g]);

    always_ff @(posedge clk) begin
      if (rst) begin
        lo_q[g]    <= '{vec: 8'h00, mode: 3'd0, pol: 1'b0, trig: 1'b0, mask: 1'b1};
        hi_q[g]    <= '0;
        dst_q[g]   <= '0;
        rirr_q[g]  <= 1'b0;
        epend_q[g] <= 1'b0;
      end else begin
        if (lo_we[g]) begin
          lo_q[g]  <= lo_from_word(reg_wdata);
          dst_q[g] <= hi_q[g];
        end
        if (hi_we[g]) hi_q[g] <= reg_wdata[31:16];
        if (grant[g] && trig_v[g])  rirr_q[g] <= 1'b1;
        else if (eoi_hit[g])        rirr_q[g] <= 1'b0;
        if (mask_v[g] || trig_v[g]) epend_q[g] <= 1'b0;
        else if (rise[g])           epend_q[g] <= 1'b1;
        else if (grant[g])          epend_q[g] <= 1'b0;
      end
    end

    // R6
    rp_hold_chk: assert property (@(posedge clk) disable iff (rst)
      rirr_q[g] && !eoi_hit[g] |=> rirr_q[g]);
    // R7
    rp_release_chk: assert property (@(posedge clk) disable iff (rst)
      rirr_q[g] && eoi_hit[g] |=> !rirr_q[g]);
  end

  // message output register
  always_ff @(posedge clk) begin
    if (rst) begin
      msg_valid  <= 1'b0;
      msg_vector <= '0;
      msg_mode   <= '0;
      msg_dest   <= '0;
      msg_pin    <= '0;
    end else if (load) begin
      msg_valid <= any;
      if (any) begin
        msg_vector <= lo_q[gidx].vec;
        msg_mode   <= lo_q[gidx].mode;
        msg_dest   <= dst_q[gidx];
        msg_pin    <= gidx;
      end
    end
  end

  // registered read port
  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else if (reg_sel == SEL_VERSION) reg_rdata <= VER_WORD;
    else if (is_tbl)
      reg_rdata <= sel_off[0] ? {hi_q[tidx], 16'h0000} : lo_to_word(lo_q[tidx], rirr_q[tidx]);
    else reg_rdata <= '0;
  end

  // R1
  rst_mask_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (&mask_v) && !msg_valid);
  // R10
  msg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    msg_valid && !msg_ready |=> msg_valid && $stable({msg_vector, msg_mode, msg_dest, msg_pin}));
  // R10
  grant_onehot_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(grant));
  // R5
  masked_grant_chk: assert property (@(posedge clk) disable iff (rst) (grant & mask_v) == '0);
endmodule

// File: tb/sim_irq_redirect_top.sv
module sim_irq_redirect_top;
  localparam int NPINS = 24;
  localparam int PW = $clog2(NPINS);

  logic clk = 1'b0, rst = 1'b1;
  logic [NPINS-1:0] irq_in = '0;
  logic [7:0]  reg_sel = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        eoi_wr = 1'b0;
  logic [7:0]  eoi_vec = '0;
  logic        msg_valid, msg_ready = 1'b0;
  logic [7:0]  msg_vector;
  logic [2:0]  msg_mode;
  logic [15:0] msg_dest;
  logic [PW-1:0] msg_pin;

  int checks = 0, failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_redirect_top #(.NPINS(NPINS), .VERSION(8'h21)) u0 (
    .clk(clk), .rst(rst), .irq_in(irq_in), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .eoi_wr(eoi_wr), .eoi_vec(eoi_vec),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_vector(msg_vector),
    .msg_mode(msg_mode), .msg_dest(msg_dest), .msg_pin(msg_pin)
  );

  function automatic logic [31:0] lo_w(input logic [7:0] v, input logic [2:0] m,
                                       input logic p, input logic t, input logic k);
    return {15'b0, k, t, 1'b0, p, 2'b00, m, v};
  endfunction

  task automatic check(input string rq, input logic [31:0] a, input logic [31:0] e);
    checks++;
    if (a !== e) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", rq, a, e);
    end
  endtask

  task automatic wr(input logic [7:0] s, input logic [31:0] d);
    @(negedge clk); reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] s, output logic [31:0] d);
    @(negedge clk); reg_sel = s;
    @(negedge clk); d = reg_rdata;
  endtask

  task automatic eoi(input logic [7:0] v);
    @(negedge clk); eoi_vec = v; eoi_wr = 1'b1;
    @(negedge clk); eoi_wr = 1'b0;
  endtask

  task automatic prog(input int i, input logic [7:0] v, input logic [2:0] m, input logic p,
                      input logic t, input logic k, input logic [15:0] d);
    wr(8'(8'h11 + 2 * i), {d, 16'h0});
    wr(8'(8'h10 + 2 * i), lo_w(v, m, p, t, k));
  endtask

  task automatic pulse(input int i);
    @(negedge clk); irq_in[i] = ~irq_in[i];
    repeat (4) @(negedge clk);
    irq_in[i] = ~irq_in[i];
  endtask

  task automatic expect_msg(input string rq, input int pin, input logic [7:0] v,
                            input logic [2:0] m, input logic [15:0] d);
    for (int n = 0; n < 20 && !msg_valid; n++) @(negedge clk);
    check(rq, {31'b0, msg_valid}, 32'd1);
    check(rq, {16'b0, msg_dest, msg_vector}, {16'b0, d, v});
    check(rq, {24'b0, 5'(msg_pin), msg_mode}, {24'b0, 5'(pin), m});
    msg_ready = 1'b1;
    @(negedge clk); msg_ready = 1'b0;
  endtask

  task automatic expect_none(input string rq);
    repeat (12) @(negedge clk);
    check(rq, {31'b0, msg_valid}, 32'd0);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd2024));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1", {31'b0, msg_valid}, 32'd0);
    for (int i = 0; i < NPINS; i++) begin
      rd(8'(8'h10 + 2 * i), d); check("R1", d, 32'h0001_0000);
    end
    rd(8'h11, d); check("R1", d, 32'h0);
    rd(8'h3F, d); check("R1", d, 32'h0);
    // R2 version
    rd(8'h01, d); check("R2", d, 32'h0017_0021);
    // R3 readback, remote-pending bit not writable
    prog(3, 8'h41, 3'd1, 1'b0, 1'b0, 1'b0, 16'h1234);
    wr(8'h16, lo_w(8'h41, 3'd1, 1'b0, 1'b0, 1'b0) | 32'h4000);
    rd(8'h16, d); check("R3", d, lo_w(8'h41, 3'd1, 1'b0, 1'b0, 1'b0));
    rd(8'h17, d); check("R3", d, 32'h1234_0000);
    // R4 one message per edge
    pulse(3);
    expect_msg("R4", 3, 8'h41, 3'd1, 16'h1234);
    expect_none("R4");
    // R5 masked edge dropped
    prog(3, 8'h41, 3'd1, 1'b0, 1'b0, 1'b1, 16'h1234);
    pulse(3);
    expect_none("R5");
    wr(8'h16, lo_w(8'h41, 3'd1, 1'b0, 1'b0, 1'b0));
    expect_none("R5");
    // R6 level with remote-pending
    prog(5, 8'h60, 3'd0, 1'b0, 1'b1, 1'b0, 16'h0102);
    @(negedge clk); irq_in[5] = 1'b1;
    expect_msg("R6", 5, 8'h60, 3'd0, 16'h0102);
    rd(8'h1A, d); check("R6", d, lo_w(8'h60, 3'd0, 1'b0, 1'b1, 1'b0) | 32'h4000);
    expect_none("R6");
    eoi(8'h61);
    expect_none("R6");
    eoi(8'h60);
    expect_msg("R6", 5, 8'h60, 3'd0, 16'h0102);
    @(negedge clk); irq_in[5] = 1'b0;
    eoi(8'h60);
    expect_none("R6");
    // R7 one EOI releases both sharers; R10 order
    prog(7, 8'h70, 3'd1, 1'b0, 1'b1, 1'b0, 16'h0700);
    prog(9, 8'h70, 3'd1, 1'b0, 1'b1, 1'b0, 16'h0700);
    @(negedge clk); irq_in[7] = 1'b1; irq_in[9] = 1'b1;
    expect_msg("R7", 7, 8'h70, 3'd1, 16'h0700);
    expect_msg("R7", 9, 8'h70, 3'd1, 16'h0700);
    expect_none("R7");
    eoi(8'h70);
    expect_msg("R7", 7, 8'h70, 3'd1, 16'h0700);
    expect_msg("R7", 9, 8'h70, 3'd1, 16'h0700);
    @(negedge clk); irq_in[7] = 1'b0; irq_in[9] = 1'b0;
    eoi(8'h70);
    expect_none("R7");
    // R8 active-low
    @(negedge clk); irq_in[11] = 1'b1;
    repeat (4) @(negedge clk);
    prog(11, 8'h22, 3'd2, 1'b1, 1'b0, 1'b0, 16'h0B00);
    expect_none("R8");
    pulse(11);
    expect_msg("R8", 11, 8'h22, 3'd2, 16'h0B00);
    expect_none("R8");
    // R9 staged destination
    prog(13, 8'h33, 3'd5, 1'b0, 1'b0, 1'b0, 16'h0A0B);
    wr(8'h2B, 32'hFFEE_0000);
    pulse(13);
    expect_msg("R9", 13, 8'h33, 3'd5, 16'h0A0B);
    wr(8'h2A, lo_w(8'h33, 3'd5, 1'b0, 1'b0, 1'b0));
    pulse(13);
    expect_msg("R9", 13, 8'h33, 3'd5, 16'hFFEE);
    // R10 priority and hold
    prog(2, 8'h02, 3'd0, 1'b0, 1'b0, 1'b0, 16'h0002);
    prog(15, 8'h15, 3'd0, 1'b0, 1'b0, 1'b0, 16'h0015);
    prog(20, 8'h20, 3'd0, 1'b0, 1'b0, 1'b0, 16'h0020);
    @(negedge clk); irq_in[20] = 1'b1; irq_in[15] = 1'b1; irq_in[2] = 1'b1;
    repeat (4) @(negedge clk);
    irq_in[20] = 1'b0; irq_in[15] = 1'b0; irq_in[2] = 1'b0;
    repeat (5) @(negedge clk);
    check("R10", {27'b0, 5'(msg_pin)}, 32'd2);
    expect_msg("R10", 2, 8'h02, 3'd0, 16'h0002);
    expect_msg("R10", 15, 8'h15, 3'd0, 16'h0015);
    expect_msg("R10", 20, 8'h20, 3'd0, 16'h0020);
    // R4 random edge entries
    for (int it = 0; it < 30; it++) begin
      int p;
      logic [7:0] v;
      logic [2:0] m;
      logic [15:0] dd;
      p = int'($urandom_range(NPINS - 1));
      if (p == 11) p = 12;
      v = 8'($urandom);
      dd = 16'($urandom);
      case ($urandom_range(3))
        0: m = 3'd0;
        1: m = 3'd1;
        2: m = 3'd2;
        default: m = 3'd5;
      endcase
      prog(p, v, m, 1'b0, 1'b0, 1'b0, dd);
      pulse(p);
      expect_msg("R4", p, v, m, dd);
    end
    expect_none("R4");
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule